// File: doc/BRIEF.md
# Programmable CRC-32 Register Peripheral

This block is a memory-mapped CRC engine behind a plain 32-bit register bus with an address, a write enable, write data and combinational read data. Software sets a 32-bit seed, a 32-bit generator polynomial and a small control word. A command bit copies the seed into the running checksum. After that, each 32-bit write to the data register folds one whole word into the checksum. A read of the data register returns the current value without disturbing it.

The engine runs MSB-first in the normal (non-reflected) domain and uses whatever polynomial is programmed. Bit-reversal options on the incoming word and on the read-back value let the same engine produce reflected checksums such as CRC-32 and CRC-32C. For those, software writes the reversed seed and the normal-form polynomial. Software also applies any final inversion; the block never inverts the result.

Top module: `crc_regblock`

## Requirements
- R1: After reset the seed register reads 0xFFFFFFFF, the polynomial register reads 0x04C11DB7, the control register reads 0 and the data register reads 0xFFFFFFFF.
- R2: Registers sit at byte offsets data 0x00, control 0x08, seed 0x10 and polynomial 0x14. The seed and polynomial registers accept and read back any 32-bit value.
- R3: A control write with bit 0 set loads the seed register into the running checksum on that clock edge. Bit 0 always reads back as 0.
- R4: Control bits 7:5 read back as written. Every other control bit reads 0. A control write with bit 0 clear leaves the checksum unchanged.
- R5: A data write replaces the checksum C with the result of 32 MSB-first steps applied to C XOR W, where W is the word after input reversal. In each step the value shifts left by one, and the polynomial is XORed in when the bit shifted out was 1. A read in the next cycle returns the updated value.
- R6: Control bits 6:5 select the input reversal. 00 passes the word through. 01 reverses the bits inside each byte. 10 reverses the bits inside each 16-bit half. 11 reverses the whole 32-bit word.
- R7: With control bit 7 set, a read of the data register returns the checksum with all 32 bits reversed. With bit 7 clear, it returns the checksum as is.
- R8: Reading any register, and writing the seed or polynomial register, never changes the running checksum.
- R9: With control bits 7:5 all set, the reversed seed in the seed register and the normal-form polynomial loaded, the data register returns the reflected CRC-32 (0x04C11DB7) or CRC-32C (0x1EDC6F41) state of the bytes in little-endian order, without final inversion.
- R10: Reads at any offset other than the four mapped ones return 0. Writes there change no register and leave the checksum unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | ADDR_W (5) | Byte offset of the accessed register |
| regWe | input | 1 | Write enable for the current cycle |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr, combinational |

## Verification
The fold is exercised with single words and with chains of words under each of the four input-reversal modes. A wrong lane width or a wrong lane order gives a different checksum in each mode, so each mode is told apart from the others. Fully reflected runs with the CRC-32 and CRC-32C polynomials, using both the all-ones seed and an asymmetric seed, are compared against a byte-serial LSB-first model. That model shares no structure with the word-wide engine, so these runs expose errors in seed handling, polynomial use and output reversal. Repeated reads and writes to unmapped offsets between folds show whether any access leaks into the checksum.

// File: rtl/crc_regs_pkg.sv
package crc_regs_pkg;
  localparam int WORD_W = 32;

  // Byte offsets of the register map
  localparam logic [7:0] OFF_DATA = 8'h00;
  localparam logic [7:0] OFF_CTRL = 8'h08;
  localparam logic [7:0] OFF_SEED = 8'h10;
  localparam logic [7:0] OFF_POLY = 8'h14;

  // Control word fields
  localparam int CTL_LOAD_BIT   = 0;
  localparam int CTL_INMODE_LSB = 5;
  localparam int CTL_OUTREV_BIT = 7;

  typedef enum logic [1:0] {
    IN_PLAIN = 2'b00,
    IN_BYTE  = 2'b01,
    IN_HALF  = 2'b10,
    IN_WORD  = 2'b11
  } inMode_e;

  typedef struct packed {
    logic loadSeed;
    logic foldWord;
  } crcStrobe_t;

  // Reverse bit order inside each lane of laneW bits
  function automatic logic [WORD_W-1:0] laneReverse(input logic [WORD_W-1:0] w,
                                                    input int laneW);
    logic [WORD_W-1:0] r;
    r = '0;
    for (int i = 0; i < WORD_W; i++) begin
      r[(i / laneW) * laneW + laneW - 1 - (i % laneW)] = w[i];
    end
    return r;
  endfunction
endpackage

// File: rtl/crc_ctrl.sv
module crc_ctrl
  import crc_regs_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter logic [WORD_W-1:0] SEED_RST = 32'hFFFF_FFFF,
  parameter logic [WORD_W-1:0] POLY_RST = 32'h04C1_1DB7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [WORD_W-1:0] regWdata,
  input  logic [WORD_W-1:0] crcView,
  output logic [WORD_W-1:0] regRdata,
  output crcStrobe_t        strobe,
  output inMode_e           inMode,
  output logic              outRev,
  output logic [WORD_W-1:0] seedVal,
  output logic [WORD_W-1:0] polyVal
);
  logic hitData, hitCtrl, hitSeed, hitPoly;
  logic [WORD_W-1:0] ctrlView;

  assign hitData = (regAddr == ADDR_W'(OFF_DATA));
  assign hitCtrl = (regAddr == ADDR_W'(OFF_CTRL));
  assign hitSeed = (regAddr == ADDR_W'(OFF_SEED));
  assign hitPoly = (regAddr == ADDR_W'(OFF_POLY));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inMode  <= IN_PLAIN;
      outRev  <= 1'b0;
      seedVal <= SEED_RST;
      polyVal <= POLY_RST;
    end else if (regWe) begin
      if (hitCtrl) begin
        inMode <= inMode_e'(regWdata[CTL_INMODE_LSB +: 2]);
        outRev <= regWdata[CTL_OUTREV_BIT];
      end
      if (hitSeed) seedVal <= regWdata;
      if (hitPoly) polyVal <= regWdata;
    end
  end

  // Load command has priority over any fold in the same cycle
  always_comb begin
    strobe.loadSeed = regWe && hitCtrl && regWdata[CTL_LOAD_BIT];
    strobe.foldWord = regWe && hitData && !strobe.loadSeed;
  end

  always_comb begin
    ctrlView = '0;
    ctrlView[CTL_INMODE_LSB +: 2] = inMode;
    ctrlView[CTL_OUTREV_BIT]      = outRev;
  end

  always_comb begin
    if (hitData)      regRdata = crcView;
    else if (hitCtrl) regRdata = ctrlView;
    else if (hitSeed) regRdata = seedVal;
    else if (hitPoly) regRdata = polyVal;
    else              regRdata = '0;
  end
endmodule

// File: rtl/crc_datapath.sv
module crc_datapath
  import crc_regs_pkg::*;
#(
  parameter logic [WORD_W-1:0] SEED_RST = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  crcStrobe_t        strobe,
  input  inMode_e           inMode,
  input  logic              outRev,
  input  logic [WORD_W-1:0] wrWord,
  input  logic [WORD_W-1:0] seedVal,
  input  logic [WORD_W-1:0] polyVal,
  output logic [WORD_W-1:0] crcState,
  output logic [WORD_W-1:0] crcView
);
  localparam int STEPS = WORD_W;

  logic [WORD_W-1:0] inWord;
  logic [WORD_W-1:0] stage [STEPS+1];

  always_comb begin
    case (inMode)
      IN_BYTE: inWord = laneReverse(wrWord, 8);
      IN_HALF: inWord = laneReverse(wrWord, 16);
      IN_WORD: inWord = laneReverse(wrWord, WORD_W);
      default: inWord = wrWord;
    endcase
  end

  assign stage[0] = crcState ^ inWord;

  generate
    for (genvar s = 0; s < STEPS; s++) begin : g_step
      assign stage[s+1] = stage[s][WORD_W-1] ? ((stage[s] << 1) ^ polyVal)
                                             : (stage[s] << 1);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                crcState <= SEED_RST;
    else if (strobe.loadSeed) crcState <= seedVal;
    else if (strobe.foldWord) crcState <= stage[STEPS];
  end

  assign crcView = outRev ? laneReverse(crcState, WORD_W) : crcState;
endmodule

// File: rtl/crc_regblock.sv
module crc_regblock
  import crc_regs_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter logic [31:0] SEED_RST = 32'hFFFF_FFFF,
  parameter logic [31:0] POLY_RST = 32'h04C1_1DB7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata
);
  crcStrobe_t        strobe;
  inMode_e           inMode;
  logic              outRev;
  logic [WORD_W-1:0] seedVal, polyVal, crcState, crcView;

  crc_ctrl #(.ADDR_W(ADDR_W), .SEED_RST(SEED_RST), .POLY_RST(POLY_RST)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
    .crcView(crcView), .regRdata(regRdata), .strobe(strobe), .inMode(inMode),
    .outRev(outRev), .seedVal(seedVal), .polyVal(polyVal)
  );

  crc_datapath #(.SEED_RST(SEED_RST)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inMode(inMode), .outRev(outRev),
    .wrWord(regWdata), .seedVal(seedVal), .polyVal(polyVal),
    .crcState(crcState), .crcView(crcView)
  );
endmodule

// File: rtl/crc_regblock_chk.sv
module crc_regblock_chk
  import crc_regs_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWe,
  input logic [31:0]       regWdata,
  input logic [31:0]       regRdata,
  input logic [31:0]       crcState,
  input logic [31:0]       seedVal,
  input logic [31:0]       polyVal
);
  logic armed;
  logic aData, aCtrl, aSeed, aPoly;

  assign aData = (regAddr == ADDR_W'(OFF_DATA));
  assign aCtrl = (regAddr == ADDR_W'(OFF_CTRL));
  assign aSeed = (regAddr == ADDR_W'(OFF_SEED));
  assign aPoly = (regAddr == ADDR_W'(OFF_POLY));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // R10: unmapped offsets read zero
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!aData && !aCtrl && !aSeed && !aPoly) |-> (regRdata == 32'h0));

  // R4 and R3: only bits 7:5 of control can read as one
  p_ctrl_readback_r4: assert property (@(posedge clk) disable iff (!rstN)
    aCtrl |-> ((regRdata & 32'hFFFF_FF1F) == 32'h0));

  // R3: load command copies the seed into the checksum
  p_seed_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(regWe && aCtrl && regWdata[0])) |-> (crcState == $past(seedVal)));

  // R8: checksum holds unless a fold or a load was requested
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(!(regWe && (aData || (aCtrl && regWdata[0])))))
      |-> (crcState == $past(crcState)));

  // R2: polynomial register takes the written value
  p_poly_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(regWe && aPoly)) |-> (polyVal == $past(regWdata)));
endmodule

bind crc_regblock crc_regblock_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
  .regRdata(regRdata), .crcState(crcState), .seedVal(seedVal), .polyVal(polyVal)
);

// File: tb/crc_regblock_tb.sv
module crc_regblock_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;

  int testsRun = 0;
  int testsFailed = 0;
  logic sampleReq = 1'b0;
  logic [31:0] expQ[$];
  string tagQ[$];

  // bench model state
  logic [31:0] mCrc, mPoly, mSeed;
  logic [1:0]  mMode;
  logic        mOutRev;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc_regblock u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata)
  );

  function automatic logic [31:0] rev32(input logic [31:0] x);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[31-i] = x[i];
    return r;
  endfunction

  function automatic logic [31:0] revMode(input logic [31:0] x, input logic [1:0] m);
    logic [31:0] r;
    r = x;
    if (m == 2'b11) r = rev32(x);
    else if (m == 2'b01)
      for (int b = 0; b < 4; b++)
        for (int j = 0; j < 8; j++) r[b*8 + j] = x[b*8 + 7 - j];
    else if (m == 2'b10)
      for (int h = 0; h < 2; h++)
        for (int j = 0; j < 16; j++) r[h*16 + j] = x[h*16 + 15 - j];
    return r;
  endfunction

  // bit-serial MSB-first model
  function automatic logic [31:0] serialFold(input logic [31:0] c, input logic [31:0] w,
                                             input logic [31:0] p);
    logic fb;
    for (int b = 31; b >= 0; b--) begin
      fb = c[31] ^ w[b];
      c = c << 1;
      if (fb) c = c ^ p;
    end
    return c;
  endfunction

  // byte-serial reflected model, LSB-first
  function automatic logic [31:0] reflWord(input logic [31:0] s, input logic [31:0] w,
                                           input logic [31:0] pr);
    for (int k = 0; k < 4; k++) begin
      s = s ^ {24'h0, w[k*8 +: 8]};
      for (int j = 0; j < 8; j++) s = s[0] ? ((s >> 1) ^ pr) : (s >> 1);
    end
    return s;
  endfunction

  // monitor: pops expected values as read results appear
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (sampleReq) begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        testsRun++;
        if (regRdata !== e) begin
          testsFailed++;
          $display("FAIL %s: actual %h expected %h", t, regRdata, e);
        end
      end
    end
  end

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a[AW-1:0];
    regWdata = d;
    regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic expectRead(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    regAddr = a[AW-1:0];
    regWe = 1'b0;
    expQ.push_back(e);
    tagQ.push_back(tag);
    sampleReq = 1'b1;
    @(negedge clk);
    sampleReq = 1'b0;
  endtask

  function automatic logic [31:0] viewCrc();
    return mOutRev ? rev32(mCrc) : mCrc;
  endfunction

  task automatic setCtrl(input logic [31:0] v);
    busWrite(8'h08, v);
    mMode = v[6:5];
    mOutRev = v[7];
    if (v[0]) mCrc = mSeed;
  endtask

  task automatic foldCheck(input logic [31:0] w, input string tag);
    busWrite(8'h00, w);
    mCrc = serialFold(mCrc, revMode(w, mMode), mPoly);
    expectRead(8'h00, viewCrc(), tag);
  endtask

  task automatic reflRun(input logic [31:0] polyNorm, input logic [31:0] seedRefl,
                         input string tag);
    logic [31:0] st;
    logic [31:0] words[3];
    words[0] = 32'h3433_3231; words[1] = 32'h3837_3635; words[2] = 32'hDEAD_0039;
    busWrite(8'h14, polyNorm); mPoly = polyNorm;
    busWrite(8'h10, rev32(seedRefl)); mSeed = rev32(seedRefl);
    setCtrl(32'h0000_00E1);
    st = seedRefl;
    expectRead(8'h00, st, tag);
    for (int i = 0; i < 3; i++) begin
      busWrite(8'h00, words[i]);
      st = reflWord(st, words[i], rev32(polyNorm));
      expectRead(8'h00, st, tag);
    end
  endtask

  initial begin
    mCrc = 32'hFFFF_FFFF; mPoly = 32'h04C1_1DB7; mSeed = 32'hFFFF_FFFF;
    mMode = 2'b00; mOutRev = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset values
    expectRead(8'h10, 32'hFFFF_FFFF, "R1 seed reset");
    expectRead(8'h14, 32'h04C1_1DB7, "R1 poly reset");
    expectRead(8'h08, 32'h0, "R1 ctrl reset");
    expectRead(8'h00, 32'hFFFF_FFFF, "R1 data reset");

    // R10: unmapped offsets
    expectRead(8'h04, 32'h0, "R10 read 0x04");
    expectRead(8'h0C, 32'h0, "R10 read 0x0C");
    expectRead(8'h18, 32'h0, "R10 read 0x18");
    busWrite(8'h04, 32'h1234_5678);
    busWrite(8'h1C, 32'hA5A5_A5A5);
    expectRead(8'h00, 32'hFFFF_FFFF, "R10 checksum untouched");
    expectRead(8'h10, 32'hFFFF_FFFF, "R10 seed untouched");
    expectRead(8'h14, 32'h04C1_1DB7, "R10 poly untouched");

    // R2: seed and poly readback
    busWrite(8'h10, 32'h1234_5678); mSeed = 32'h1234_5678;
    busWrite(8'h14, 32'h1EDC_6F41); mPoly = 32'h1EDC_6F41;
    expectRead(8'h10, 32'h1234_5678, "R2 seed readback");
    expectRead(8'h14, 32'h1EDC_6F41, "R2 poly readback");
    expectRead(8'h00, 32'hFFFF_FFFF, "R8 seed/poly writes keep checksum");

    // R3: load command
    setCtrl(32'h0000_0001);
    expectRead(8'h00, 32'h1234_5678, "R3 seed loaded");
    expectRead(8'h08, 32'h0, "R3 load bit reads zero");

    // R5: plain fold chain
    foldCheck(32'h0000_0000, "R5 fold zero word");
    foldCheck(32'hCAFE_F00D, "R5 fold word A");
    foldCheck(32'h8000_0001, "R5 fold word B");
    expectRead(8'h00, viewCrc(), "R8 repeated read stable");
    expectRead(8'h00, viewCrc(), "R8 second repeated read");

    // R6: input modes
    setCtrl(32'h0000_0021);
    foldCheck(32'h0102_0380, "R6 byte reverse");
    foldCheck(32'hF00F_1234, "R6 byte reverse second");
    setCtrl(32'h0000_0041);
    foldCheck(32'h0102_0380, "R6 half reverse");
    setCtrl(32'h0000_0061);
    foldCheck(32'h0102_0380, "R6 word reverse");

    // R4: control readback and no effect with bit 0 clear
    setCtrl(32'hFFFF_FF1E);
    expectRead(8'h08, 32'h0, "R4 other bits read zero");
    setCtrl(32'hFFFF_FFFE);
    expectRead(8'h08, 32'h0000_00E0, "R4 bits 7:5 read back");
    // R7: output reversal active now
    expectRead(8'h00, viewCrc(), "R7 reversed readback");
    setCtrl(32'h0000_0060);
    expectRead(8'h00, viewCrc(), "R7 plain readback");

    // R9: reflected runs
    reflRun(32'h04C1_1DB7, 32'hFFFF_FFFF, "R9 CRC-32 all-ones seed");
    reflRun(32'h1EDC_6F41, 32'hFFFF_FFFF, "R9 CRC-32C all-ones seed");
    reflRun(32'h04C1_1DB7, 32'h1357_9BDF, "R9 CRC-32 asymmetric seed");

    repeat (2) @(negedge clk);
    if (expQ.size() != 0) begin
      testsFailed++;
      $display("FAIL scoreboard: actual %0d pending expected 0", expQ.size());
    end
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule